// File: doc/BRIEF.md
# Sign-Magnitude Adder-Subtractor

This combinational block adds or subtracts two numbers held in sign-magnitude form. Each operand is WIDTH bits wide. The top bit is the sign and the bits below it are an unsigned magnitude. A single control input selects subtraction. Subtraction flips the sign of the second operand, and the block then applies the ordinary addition rules.

The block compares the first operand's sign with the effective sign of the second operand. When the two signs agree, the magnitudes are summed and the result takes the shared sign. A carry out of the magnitude field raises the overflow flag. When the signs disagree, the second magnitude is subtracted from the first. If that subtraction borrows, the difference is replaced by its two's complement and the result sign becomes the inverse of the first operand's sign. The result never carries a negative zero, and negative-zero operands are treated as plain zero.

Top module: `smas_top`

## Requirements
- R1: Operands and result use bit WIDTH-1 as the sign (0 positive, 1 negative) and bits WIDTH-2..0 as an unsigned magnitude.
- R2: With `sub_i` = 1 the sign of `b_i` is inverted before any other rule is applied; with `sub_i` = 0 it is used as given.
- R3: When the first sign equals the effective second sign and the magnitude sum fits in WIDTH-1 bits, the result magnitude is the sum, the sign is the shared sign and `ovf_o` is 0.
- R4: When the signs agree and the magnitude sum carries out of WIDTH-1 bits, `ovf_o` is 1, the result magnitude is the low WIDTH-1 bits of the sum and the sign is the shared sign.
- R5: When the signs differ and |A| >= |B|, the result magnitude is |A| - |B| and the sign is A's sign, unless R8 applies.
- R6: When the signs differ and |A| < |B| (a borrow), the result magnitude is |B| - |A| and the sign is the inverse of A's sign.
- R7: `ovf_o` is always 0 when the signs differ.
- R8: Without overflow, a zero result magnitude always carries sign 0.
- R9: An operand with sign 1 and zero magnitude behaves exactly like zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, sign-magnitude |
| b_i | input | WIDTH | Second operand, sign-magnitude |
| sub_i | input | 1 | 1 selects A - B, 0 selects A + B |
| res_o | output | WIDTH | Sign-magnitude result |
| ovf_o | output | 1 | Magnitude overflow when the signs agree |

## Verification
Each pairing of operand signs is tried with both values of the control input. This separates a wrong effective-sign decision from a wrong magnitude path. Equal magnitudes with opposite signs check the positive-zero rule, and negative-zero operands check that a set sign on a zero magnitude changes nothing. Sums just under, at and above the magnitude limit separate a missed overflow from a false one. Borrowing and non-borrowing differences test the complement correction and the sign inversion. A deterministic sweep over many operand pairs compares every output against an integer reference.

// File: rtl/smas_pkg.sv
package smas_pkg;
  typedef enum logic {
    MAG_SUM  = 1'b0,
    MAG_DIFF = 1'b1
  } mag_op_e;
endpackage

// File: rtl/smas_sign_unit.sv
module smas_sign_unit (
  input  logic a_sign,
  input  logic b_sign,
  input  logic sub,
  output logic b_eff_sign,
  output logic same_sign
);
  always_comb begin
    b_eff_sign = b_sign ^ sub;
    same_sign  = (a_sign == b_eff_sign);
  end
endmodule

// File: rtl/smas_mag_add.sv
module smas_mag_add #(
  parameter int MAG_W = 7
) (
  input  logic [MAG_W-1:0] a_mag,
  input  logic [MAG_W-1:0] b_mag,
  output logic [MAG_W-1:0] sum,
  output logic             carry
);
  function automatic logic [MAG_W:0] wide_sum(input logic [MAG_W-1:0] x,
                                               input logic [MAG_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  logic [MAG_W:0] full;
  always_comb begin
    full  = wide_sum(a_mag, b_mag);
    sum   = full[MAG_W-1:0];
    carry = full[MAG_W];
  end
endmodule

// File: rtl/smas_mag_sub.sv
module smas_mag_sub #(
  parameter int MAG_W = 7
) (
  input  logic [MAG_W-1:0] a_mag,
  input  logic [MAG_W-1:0] b_mag,
  output logic [MAG_W-1:0] diff,
  output logic             borrow
);
  localparam logic [MAG_W-1:0] ONE = {{(MAG_W-1){1'b0}}, 1'b1};

  function automatic logic [MAG_W:0] wide_diff(input logic [MAG_W-1:0] x,
                                                input logic [MAG_W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  function automatic logic [MAG_W-1:0] twos(input logic [MAG_W-1:0] v);
    return ~v + ONE;
  endfunction

  logic [MAG_W:0] raw;
  always_comb begin
    raw    = wide_diff(a_mag, b_mag);
    borrow = raw[MAG_W];
    diff   = borrow ? twos(raw[MAG_W-1:0]) : raw[MAG_W-1:0];
  end
endmodule

// File: rtl/smas_top.sv
module smas_top #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             ovf_o
);
  import smas_pkg::*;

  localparam int MAG_W = WIDTH - 1;
  localparam int SGN   = WIDTH - 1;

  logic             a_sign;
  logic             b_eff_sign;
  logic             same_sign;
  logic [MAG_W-1:0] a_mag;
  logic [MAG_W-1:0] b_mag;
  logic [MAG_W-1:0] sum_mag;
  logic             add_carry;
  logic [MAG_W-1:0] diff_mag;
  logic             sub_borrow;
  mag_op_e          op;
  logic [MAG_W-1:0] res_mag;
  logic             raw_sign;
  logic             mag_zero;

  assign a_sign = a_i[SGN];
  assign a_mag  = a_i[MAG_W-1:0];
  assign b_mag  = b_i[MAG_W-1:0];

  smas_sign_unit u_sign (
    .a_sign     (a_sign),
    .b_sign     (b_i[SGN]),
    .sub        (sub_i),
    .b_eff_sign (b_eff_sign),
    .same_sign  (same_sign)
  );

  smas_mag_add #(.MAG_W(MAG_W)) u_add (
    .a_mag (a_mag),
    .b_mag (b_mag),
    .sum   (sum_mag),
    .carry (add_carry)
  );

  smas_mag_sub #(.MAG_W(MAG_W)) u_sub (
    .a_mag  (a_mag),
    .b_mag  (b_mag),
    .diff   (diff_mag),
    .borrow (sub_borrow)
  );

  always_comb begin
    op = same_sign ? MAG_SUM : MAG_DIFF;
    unique case (op)
      MAG_SUM: begin
        res_mag  = sum_mag;
        raw_sign = a_sign;
        ovf_o    = add_carry;
      end
      default: begin
        res_mag  = diff_mag;
        raw_sign = sub_borrow ? ~a_sign : a_sign;
        ovf_o    = 1'b0;
      end
    endcase
    mag_zero = (res_mag == '0);
    res_o    = {raw_sign & ~(mag_zero & ~ovf_o), res_mag};
  end
endmodule

// File: rtl/smas_checker.sv
module smas_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] res_o,
  input logic             ovf_o,
  input logic             same_sign,
  input logic             sub_borrow,
  input logic             b_eff_sign
);
  localparam int MAG_W = WIDTH - 1;

  always_comb begin
    // R7: differing signs never overflow
    p_no_overflow_r7: assert (same_sign || !ovf_o);
    // R3/R4: agreeing signs keep the shared sign on a nonzero or overflowed result
    if (same_sign && (ovf_o || res_o[MAG_W-1:0] != '0))
      p_shared_sign_r3: assert (res_o[WIDTH-1] == a_i[WIDTH-1]);
    // R6: a borrow flips the sign relative to A
    if (!same_sign && sub_borrow)
      p_borrow_sign_r6: assert (res_o[WIDTH-1] == ~a_i[WIDTH-1]);
    // R8: no negative zero without overflow
    if (!ovf_o && res_o[MAG_W-1:0] == '0)
      p_pos_zero_r8: assert (res_o[WIDTH-1] == 1'b0);
    // R2: effective sign of B follows the control input
    p_eff_sign_r2: assert (b_eff_sign == (b_i[WIDTH-1] ^ sub_i));
  end
endmodule

bind smas_top smas_checker #(.WIDTH(WIDTH)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .sub_i      (sub_i),
  .res_o      (res_o),
  .ovf_o      (ovf_o),
  .same_sign  (same_sign),
  .sub_borrow (sub_borrow),
  .b_eff_sign (b_eff_sign)
);

// File: tb/smas_top_test.sv
module smas_top_test;
  localparam int W     = 8;
  localparam int MW    = W - 1;
  localparam int MAXM  = (1 << MW) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a, b;
  logic         sub;
  logic [W-1:0] res;
  logic         ovf;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  always #2 clk = ~clk;

  smas_top #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b), .sub_i(sub), .res_o(res), .ovf_o(ovf)
  );

  function automatic logic [W-1:0] enc(input bit s, input int m);
    return {s, m[MW-1:0]};
  endfunction

  task automatic apply_chk(input string tag, input logic [W-1:0] av,
                           input logic [W-1:0] bv, input logic s);
    int va, vb, tot, amag, emag;
    bit eovf, esgn;
    logic [W-1:0] eres;
    @(negedge clk);
    a = av; b = bv; sub = s;
    #1;
    va = av[W-1] ? -int'(av[MW-1:0]) : int'(av[MW-1:0]);
    vb = bv[W-1] ? -int'(bv[MW-1:0]) : int'(bv[MW-1:0]);
    if (s) vb = -vb;
    tot  = va + vb;
    amag = tot < 0 ? -tot : tot;
    eovf = amag > MAXM;
    emag = amag % (MAXM + 1);
    esgn = tot < 0;
    eres = enc(esgn, emag);
    n_chk++;
    if (res !== eres || ovf !== eovf) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h sub=%0d: res=%h ovf=%0d expected res=%h ovf=%0d",
               tag, av, bv, s, res, ovf, eres, eovf);
    end
  endtask

  task automatic t_reset;   // R1: all-zero inputs give positive zero
    apply_chk("R1", '0, '0, 1'b0);
  endtask

  task automatic t_same_sign;   // R3
    apply_chk("R3", enc(0, 20), enc(0, 35), 1'b0);
    apply_chk("R3", enc(1, 20), enc(1, 35), 1'b0);
    apply_chk("R3", enc(0, 63), enc(0, 64), 1'b0);
    apply_chk("R3", enc(1, 100), enc(0, 27), 1'b1);
  endtask

  task automatic t_overflow;    // R4
    apply_chk("R4", enc(0, 127), enc(0, 1), 1'b0);
    apply_chk("R4", enc(1, 127), enc(1, 127), 1'b0);
    apply_chk("R4", enc(0, 90), enc(1, 90), 1'b1);
  endtask

  task automatic t_sub_ctrl;    // R2
    apply_chk("R2", enc(0, 50), enc(0, 10), 1'b1);
    apply_chk("R2", enc(0, 50), enc(1, 10), 1'b1);
    apply_chk("R2", enc(1, 5), enc(1, 9), 1'b1);
  endtask

  task automatic t_no_borrow;   // R5, R7
    apply_chk("R5", enc(0, 80), enc(1, 30), 1'b0);
    apply_chk("R5", enc(1, 80), enc(0, 30), 1'b0);
    apply_chk("R7", enc(0, 127), enc(1, 127), 1'b0);
  endtask

  task automatic t_borrow;      // R6
    apply_chk("R6", enc(0, 30), enc(1, 80), 1'b0);
    apply_chk("R6", enc(1, 0), enc(0, 127), 1'b0);
    apply_chk("R6", enc(0, 1), enc(0, 2), 1'b1);
  endtask

  task automatic t_equal_mags;  // R8: every sign pairing, both ops
    for (int sa = 0; sa < 2; sa++)
      for (int sb = 0; sb < 2; sb++)
        for (int op = 0; op < 2; op++) begin
          apply_chk("R8", enc(sa[0], 45), enc(sb[0], 45), op[0]);
          apply_chk("R8", enc(sa[0], 127), enc(sb[0], 127), op[0]);
        end
  endtask

  task automatic t_negzero;     // R9
    apply_chk("R9", enc(1, 0), enc(1, 0), 1'b0);
    apply_chk("R9", enc(1, 0), enc(0, 0), 1'b1);
    apply_chk("R9", enc(1, 0), enc(0, 17), 1'b0);
    apply_chk("R9", enc(0, 17), enc(1, 0), 1'b1);
  endtask

  task automatic t_sweep;       // R1..R9 over many operand pairs
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply_chk("R1_sweep", lfsr[15:8], lfsr[7:0], lfsr[3] ^ lfsr[11]);
    end
  endtask

  initial begin
    a = '0; b = '0; sub = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_same_sign();
    t_overflow();
    t_sub_ctrl();
    t_no_borrow();
    t_borrow();
    t_equal_mags();
    t_negzero();
    t_sweep();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule